// File: doc/BRIEF.md
# Two-register I2C control target

This block is an I2C target that holds the control settings for a pair of powered output channels and reports their diagnostic flags. A host writes one data byte per transfer. The top bit of that byte picks channel A's register or channel B's register, and the remaining bits land in that register's control fields. A read returns both register images, channel A first, with the live fault flags mixed into the read-only positions.

SCL and SDA are sampled on the block's own clock. Each line passes through a two-flop synchroniser and a three-sample agreement filter before any START, STOP or clock-edge decision is made. The upper five bits of the seven-bit address are fixed at 00010. The two low bits come from strap pins, so four of these targets can share one bus. While the power-good input is low the target acknowledges nothing. A thermal-clear request wipes every writable bit. The SDA output is an active-high pull-down enable meant for an open-drain pad.

Top module: `lnbc_i2c_target`

## Requirements
- R1: After reset every control output is 0 and the SDA pull-down is released.
- R2: An address byte whose upper seven bits equal {5'b00010, strap_i} is acknowledged. Bit 0 of the address byte is the direction: 1 means read and 0 means write. Any other address gets no acknowledge, and the rest of the transfer up to STOP leaves the registers unchanged.
- R3: In a written data byte, bit 7 = 0 selects channel A, and bits 6..1 load ctl_a_o[5:0], which holds {dynamic limit, high current, tone, cable compensation, high voltage, enable}. Bit 7 = 1 selects channel B, and bits 6..2 load ctl_b_o[4:0], which holds {high current, tone, cable compensation, high voltage, enable}. The written data byte is acknowledged.
- R4: Written bits that land on read-only positions are ignored. These are bit 0 for channel A and bits 1..0 for channel B. Those positions always read back the live flag inputs.
- R5: A read sends the channel A image {0, ctl_a_o, ovl_a_i} first and then the channel B image {1, ctl_b_o, hot_i, ovl_b_i}, each MSB first. While the host keeps acknowledging, the two images keep alternating.
- R6: When the host does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START.
- R7: While pwr_ok_i is low, neither the address nor the data is acknowledged, and the registers keep their values.
- R8: A high therm_clr_i clears every writable bit in the next cycle. The clear takes priority over a write in the same cycle.
- R9: Only the first data byte of a write transfer is taken. Later bytes get no acknowledge and have no effect.
- R10: A pulse on SCL or SDA lasting two sample clocks or less is ignored. The target changes its SDA drive only while the filtered SCL is low.
- R11: A STOP in the middle of a data byte ends the transfer without any register change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Low two address bits |
| pwr_ok_i | input | 1 | Power good; low blocks every acknowledge |
| ovl_a_i | input | 1 | Channel A overload flag, read-only |
| ovl_b_i | input | 1 | Channel B overload flag, read-only |
| hot_i | input | 1 | Over-temperature flag, read-only |
| therm_clr_i | input | 1 | Clear request for all writable bits |
| sda_pd_o | output | 1 | Pull SDA low when 1 |
| ctl_a_o | output | 6 | Channel A control bits |
| ctl_b_o | output | 5 | Channel B control bits |

## Verification
The hardest conditions to reach from the ports are bus events that must *not* register. These are short spikes on either line during a clock-high phase, a STOP that cuts a data byte short, and a second data byte inside one write transfer. The bench's bus master therefore has hooks that insert two-cycle spikes in the middle of a high phase, abandon a byte after four bits, or keep clocking bytes after the first. Each case is followed by a read-back through the normal protocol. Randomised straps, addresses, data and flag levels then cover matching and non-matching transfers against a register model held in the bench.

// File: rtl/lnbc_pkg.sv
package lnbc_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CTL_A_W = 6;
  localparam int unsigned CTL_B_W = 5;
  localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } i2c_st_e;

  function automatic logic addr_hit(input logic [6:0] a, input logic [4:0] hi,
                                    input logic [1:0] strap);
    return a == {hi, strap};
  endfunction

  function automatic logic [BYTE_W-1:0] image_a(input logic [CTL_A_W-1:0] c,
                                                input logic ovl);
    return {1'b0, c, ovl};
  endfunction

  function automatic logic [BYTE_W-1:0] image_b(input logic [CTL_B_W-1:0] c,
                                                input logic hot, input logic ovl);
    return {1'b1, c, hot, ovl};
  endfunction

endpackage

// File: rtl/lnbc_line_filter.sv
module lnbc_line_filter #(
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned HOLD_N = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);

  logic [SYNC_N-1:0] sync_q;
  logic [HOLD_N-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      hist_q  <= '1;
      clean_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], raw_i};
      hist_q <= {hist_q[HOLD_N-2:0], sync_q[SYNC_N-1]};
      if (&hist_q)       clean_o <= 1'b1;
      else if (~|hist_q) clean_o <= 1'b0;
    end
  end

endmodule

// File: rtl/lnbc_regs.sv
module lnbc_regs
  import lnbc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_stb_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  input  logic               clr_i,
  output logic [CTL_A_W-1:0] ctl_a_o,
  output logic [CTL_B_W-1:0] ctl_b_o
);

  localparam int unsigned RO_B = BYTE_W - 1 - CTL_B_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_a_o <= '0;
      ctl_b_o <= '0;
    end else if (clr_i) begin
      ctl_a_o <= '0;
      ctl_b_o <= '0;
    end else if (wr_stb_i) begin
      if (wr_data_i[BYTE_W-1]) ctl_b_o <= wr_data_i[BYTE_W-2:RO_B];
      else                     ctl_a_o <= wr_data_i[BYTE_W-2:1];
    end
  end

endmodule

// File: rtl/lnbc_i2c_engine.sv
module lnbc_i2c_engine
  import lnbc_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b00010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_f_i,
  input  logic              sda_f_i,
  input  logic [1:0]        strap_i,
  input  logic              pwr_ok_i,
  input  logic [BYTE_W-1:0] img_a_i,
  input  logic [BYTE_W-1:0] img_b_i,
  output logic              sda_pd_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              start_ev_o,
  output logic              stop_ev_o,
  output logic              ack_go_o
);

  i2c_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic              scl_q, sda_q, rd_sel_q, m_ack_q;
  logic              scl_rise, scl_fall, byte_full, addr_ok;

  assign scl_rise   = scl_f_i & ~scl_q;
  assign scl_fall   = ~scl_f_i & scl_q;
  assign start_ev_o = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_ev_o  = scl_f_i & scl_q & ~sda_q & sda_f_i;
  assign byte_full  = (cnt_q == CNT_W'(BYTE_W));
  assign addr_ok    = addr_hit(sh_q[BYTE_W-1:1], ADDR_HI, strap_i);

  assign ack_go_o = scl_fall & byte_full & pwr_ok_i &
                    ((st_q == ST_ADDR & addr_ok) | (st_q == ST_WDAT));
  assign wr_stb_o  = scl_fall & byte_full & pwr_ok_i & (st_q == ST_WDAT);
  assign wr_data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      rd_sel_q <= 1'b0;
      m_ack_q  <= 1'b0;
      sda_pd_o <= 1'b0;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
      if (start_ev_o) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_pd_o <= 1'b0;
      end else if (stop_ev_o) begin
        st_q     <= ST_IDLE;
        sda_pd_o <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise && !byte_full) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_f_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (ack_go_o) begin
                sda_pd_o <= 1'b1;
                st_q     <= (st_q == ST_ADDR) ? ST_AACK : ST_WACK;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (sh_q[0]) begin
                tx_q     <= img_a_i;
                sda_pd_o <= ~img_a_i[BYTE_W-1];
                rd_sel_q <= 1'b1;
                st_q     <= ST_RDAT;
              end else begin
                sda_pd_o <= 1'b0;
                st_q     <= ST_WDAT;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_pd_o <= 1'b0;
              st_q     <= ST_SKIP;
            end
          end
          ST_RDAT: begin
            if (scl_rise && !byte_full) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                sda_pd_o <= 1'b0;
                st_q     <= ST_RACK;
              end else begin
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_pd_o <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack_q <= ~sda_f_i;
            end else if (scl_fall) begin
              if (m_ack_q) begin
                cnt_q    <= '0;
                tx_q     <= rd_sel_q ? img_b_i : img_a_i;
                sda_pd_o <= rd_sel_q ? ~img_b_i[BYTE_W-1] : ~img_a_i[BYTE_W-1];
                rd_sel_q <= ~rd_sel_q;
                st_q     <= ST_RDAT;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/lnbc_i2c_target.sv
module lnbc_i2c_target
  import lnbc_pkg::*;
#(
  parameter logic [4:0]  ADDR_HI = 5'b00010,
  parameter int unsigned SYNC_N  = 2,
  parameter int unsigned HOLD_N  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         strap_i,
  input  logic               pwr_ok_i,
  input  logic               ovl_a_i,
  input  logic               ovl_b_i,
  input  logic               hot_i,
  input  logic               therm_clr_i,
  output logic               sda_pd_o,
  output logic [CTL_A_W-1:0] ctl_a_o,
  output logic [CTL_B_W-1:0] ctl_b_o
);

  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic               scl_f, sda_f;
  logic               wr_stb, start_ev, stop_ev, ack_go;
  logic [BYTE_W-1:0]  wr_data, img_a, img_b;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    lnbc_line_filter #(.SYNC_N(SYNC_N), .HOLD_N(HOLD_N)) filt_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (raw_lines[g]),
      .clean_o (clean_lines[g])
    );
  end

  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];
  assign img_a = image_a(ctl_a_o, ovl_a_i);
  assign img_b = image_b(ctl_b_o, hot_i, ovl_b_i);

  lnbc_i2c_engine #(.ADDR_HI(ADDR_HI)) eng_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_f_i    (scl_f),
    .sda_f_i    (sda_f),
    .strap_i    (strap_i),
    .pwr_ok_i   (pwr_ok_i),
    .img_a_i    (img_a),
    .img_b_i    (img_b),
    .sda_pd_o   (sda_pd_o),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .start_ev_o (start_ev),
    .stop_ev_o  (stop_ev),
    .ack_go_o   (ack_go)
  );

  lnbc_regs regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb),
    .wr_data_i (wr_data),
    .clr_i     (therm_clr_i),
    .ctl_a_o   (ctl_a_o),
    .ctl_b_o   (ctl_b_o)
  );

endmodule

// File: rtl/lnbc_i2c_target_chk.sv
module lnbc_i2c_target_chk
  import lnbc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               therm_clr_i,
  input logic               sda_pd_o,
  input logic [CTL_A_W-1:0] ctl_a_o,
  input logic [CTL_B_W-1:0] ctl_b_o,
  input logic               wr_stb,
  input logic               scl_f
);

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_clr_i |=> (ctl_a_o == '0 && ctl_b_o == '0));

  a_r3_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stb && !therm_clr_i) |=> ($stable(ctl_a_o) && $stable(ctl_b_o)));

  a_r10_drive_on_low_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> !scl_f);

  a_r10_release_on_low_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pd_o) |-> !scl_f);

  a_r9_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> !wr_stb);

endmodule

bind lnbc_i2c_target lnbc_i2c_target_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .therm_clr_i (therm_clr_i),
  .sda_pd_o    (sda_pd_o),
  .ctl_a_o     (ctl_a_o),
  .ctl_b_o     (ctl_b_o),
  .wr_stb      (wr_stb),
  .scl_f       (scl_f)
);

// File: tb/lnbc_i2c_target_tb_top.sv
module lnbc_i2c_target_tb_top;

  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, scl_g = 1'b1, sda_g = 1'b1;
  logic [1:0] strap = 2'b01;
  logic pwr_ok = 1'b1, ovl_a = 1'b0, ovl_b = 1'b0, hot = 1'b0, tclr = 1'b0;
  logic sda_pd;
  logic [5:0] ctl_a;
  logic [4:0] ctl_b;
  logic sda_line;
  logic [5:0] exp_a = '0;
  logic [4:0] exp_b = '0;
  int n_chk = 0, n_bad = 0;
  bit gl_en = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pd;

  lnbc_i2c_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m & scl_g), .sda_i(sda_line & sda_g),
    .strap_i(strap), .pwr_ok_i(pwr_ok), .ovl_a_i(ovl_a), .ovl_b_i(ovl_b),
    .hot_i(hot), .therm_clr_i(tclr), .sda_pd_o(sda_pd), .ctl_a_o(ctl_a), .ctl_b_o(ctl_b)
  );

  function automatic logic [7:0] want_a();
    return {1'b0, exp_a, ovl_a};
  endfunction

  function automatic logic [7:0] want_b();
    return {1'b1, exp_b, hot, ovl_b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic high_phase();
    if (gl_en) begin
      wq(Q / 2); scl_g = 1'b0; wq(2); scl_g = 1'b1; wq(2);
      sda_g = 1'b0; wq(2); sda_g = 1'b1; wq(Q / 2 - 6);
    end else wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; high_phase(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = !sda_line;
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
    wq(2); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                          output bit a_ack, output bit d_ack);
    bus_start();
    send_byte({a, 1'b0}, a_ack);
    send_byte(d, d_ack);
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, output bit a_ack,
                         output logic [7:0] b0, output logic [7:0] b1);
    bus_start();
    send_byte({a, 1'b1}, a_ack);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    bus_stop();
  endtask

  task automatic model_write(input logic [7:0] d);
    if (d[7]) exp_b = d[6:2];
    else      exp_a = d[6:1];
  endtask

  task automatic check_regs(input string req);
    chk({req, " ctl_a"}, ctl_a, exp_a);
    chk({req, " ctl_b"}, ctl_b, exp_b);
  endtask

  task automatic check_read(input string req);
    bit ak;
    logic [7:0] b0, b1;
    do_read({5'b00010, strap}, ak, b0, b1);
    chk({req, " read ack"}, ak, 1);
    chk({req, " image A"}, b0, want_a());
    chk({req, " image B"}, b1, want_b());
  endtask

  initial begin
    bit aa, da;
    logic [7:0] b0, b1;
    void'($urandom(32'h5EED_1234));
    wq(10);
    // R1: reset state
    chk("R1 ctl_a", ctl_a, 0);
    chk("R1 ctl_b", ctl_b, 0);
    chk("R1 sda_pd", sda_pd, 0);
    rst_n = 1'b1;
    wq(10);
    chk("R1 sda after reset", sda_pd, 0);

    // R2, R3: directed writes to both registers
    do_write({5'b00010, strap}, 8'h55, aa, da);
    model_write(8'h55);
    chk("R2 addr ack", aa, 1);
    chk("R3 data ack", da, 1);
    check_regs("R3 write A");
    do_write({5'b00010, strap}, 8'hD4, aa, da);
    model_write(8'hD4);
    check_regs("R3 write B");

    // R5, R4: read both images with live flags
    ovl_a = 1'b1; hot = 1'b1; ovl_b = 1'b0;
    check_read("R5 R4 live flags");

    // R4: writes hitting read-only positions are ignored
    ovl_a = 1'b0; hot = 1'b0;
    do_write({5'b00010, strap}, 8'h01, aa, da);
    model_write(8'h01);
    do_write({5'b00010, strap}, 8'hFF, aa, da);
    model_write(8'hFF);
    check_read("R4 read-only ignored");

    // R5: continued acknowledge alternates images
    bus_start();
    send_byte({5'b00010, strap, 1'b1}, aa);
    recv_byte(1'b1, b0);
    recv_byte(1'b1, b1);
    chk("R5 alt B", b1, want_b());
    recv_byte(1'b0, b0);
    chk("R5 alt A again", b0, want_a());
    // R6: after NACK nothing is driven
    wq();
    chk("R6 released", sda_pd, 0);
    recv_byte(1'b0, b1);
    chk("R6 idle line", b1, 8'hFF);
    bus_stop();

    // R2: random strap/address/data mix
    for (int it = 0; it < 18; it++) begin
      logic [6:0] adr;
      logic [7:0] dat;
      bit hit;
      strap = 2'($urandom);
      hit = ($urandom % 3) != 0;
      adr = hit ? {5'b00010, strap} : 7'($urandom);
      if (adr == {5'b00010, strap}) hit = 1;
      dat = 8'($urandom);
      ovl_a = 1'($urandom); ovl_b = 1'($urandom); hot = 1'($urandom);
      do_write(adr, dat, aa, da);
      if (hit) model_write(dat);
      chk("R2 rand addr ack", aa, hit);
      chk("R3 rand data ack", da, hit);
      check_regs("R2 R3 random");
      if (it % 3 == 0) check_read("R5 random read");
    end

    // R7: power-good low blocks acknowledge and writes
    pwr_ok = 1'b0;
    do_write({5'b00010, strap}, {1'b0, ~exp_a, 1'b0}, aa, da);
    chk("R7 no addr ack", aa, 0);
    chk("R7 no data ack", da, 0);
    check_regs("R7 unchanged");
    pwr_ok = 1'b1;

    // R8: thermal clear wipes writable bits
    do_write({5'b00010, strap}, 8'h7E, aa, da);
    model_write(8'h7E);
    @(negedge clk); tclr = 1'b1; @(negedge clk); tclr = 1'b0;
    exp_a = '0; exp_b = '0;
    check_regs("R8 cleared");

    // R9: second data byte ignored
    bus_start();
    send_byte({5'b00010, strap, 1'b0}, aa);
    send_byte(8'h2A, da);
    send_byte(8'hFC, da);
    bus_stop();
    model_write(8'h2A);
    chk("R9 second byte nack", da, 0);
    check_regs("R9 first only");

    // R10: short spikes on both lines during high phases
    gl_en = 1'b1;
    do_write({5'b00010, strap}, 8'hBC, aa, da);
    gl_en = 1'b0;
    model_write(8'hBC);
    chk("R10 glitch ack", da, 1);
    check_regs("R10 glitch write");

    // R11: STOP in the middle of a data byte
    bus_start();
    send_byte({5'b00010, strap, 1'b0}, aa);
    send_bits(8'h66, 4);
    bus_stop();
    check_regs("R11 aborted");
    check_read("R11 readback");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule